// File: doc/BRIEF.md
# One-Shot Prescaled Down Timer

This block is a single-shot interval timer that sits on an 8-bit register write port. Software writes one byte: the top two bits pick one of four timebases, and the low six bits give a start count. The timer loads the count, decrements it once per timebase tick, and stops when the count reaches zero. At that point it raises a sticky flag for the interrupt controller. It never reloads itself. A new write clears the flag and starts a fresh interval.

All timebases come from the block's own clock, which is nominally 6 MHz. The base tick is `BASE_CYCLES` clocks, which is 1536 clocks or 0.256 ms at 6 MHz. The other three timebases are 2, 4 and 16 times that value. A `tmr_busy` output is high while a count is in progress. A written count of zero sets the flag at once, without any counting.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, `tmr_flag` and `tmr_busy` are both low.
- R2: A write with a nonzero count in bits 5..0 clears `tmr_flag` and drives `tmr_busy` high from the clock edge that samples the write.
- R3: The write byte has two fields. Bits 7..6 select the timebase multiplier: 00 gives x1, 01 gives x2, 10 gives x4 and 11 gives x16, each a multiple of `BASE_CYCLES` clocks. Bits 5..0 hold the start count N.
- R4: For a write with N > 0, `tmr_flag` rises and `tmr_busy` falls on the same clock edge. That edge is exactly N x multiplier x `BASE_CYCLES` edges after the edge that sampled the write. Before it, the flag stays low and the block stays busy.
- R5: A write with N = 0 sets `tmr_flag` and leaves `tmr_busy` low at the edge that samples the write.
- R6: Once set, `tmr_flag` stays high and `tmr_busy` stays low until the next write, however long the wait.
- R7: A write while counting restarts the timer. The prescaler restarts too, so the full new interval is measured from that write, and nothing of the old interval remains.
- R8: `tmr_flag` and `tmr_busy` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock (nominally 6 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the timer register |
| wr_data | input | 8 | Write byte: [7:6] timebase select, [5:0] start count |
| tmr_flag | output | 1 | Sticky expiry flag, cleared by a write |
| tmr_busy | output | 1 | High while counting |

## Verification
A prescaler that wraps early or late shifts the flag edge by whole timebase periods. Such an error shows up on the first interval, as a flag that is one or more timebases early or late. A wrong multiplier decode shows up as soon as that select code is written. A count or busy bit that fails to clear on a restart, or a flag that fails to stay set, appears at the ports within one timebase of the restart or at the next idle sample. So every check compares the exact edge of the flag, and the cycle just before it, with a period computed from the written byte.

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int BASE_CYCLES = 1536,
  parameter int CNT_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W+1:0] wr_data,
  output logic             tmr_flag,
  output logic             tmr_busy
);
  localparam int PRE_W = $clog2(BASE_CYCLES * 16);
  localparam logic [PRE_W-1:0] LIM_X1  = PRE_W'(BASE_CYCLES - 1);
  localparam logic [PRE_W-1:0] LIM_X2  = PRE_W'(BASE_CYCLES * 2 - 1);
  localparam logic [PRE_W-1:0] LIM_X4  = PRE_W'(BASE_CYCLES * 4 - 1);
  localparam logic [PRE_W-1:0] LIM_X16 = PRE_W'(BASE_CYCLES * 16 - 1);

  logic [1:0]       sel;
  logic [CNT_W-1:0] count;
  logic [PRE_W-1:0] pre, pre_lim;
  logic             tick;

  always_comb begin
    case (sel)
      2'b00:   pre_lim = LIM_X1;
      2'b01:   pre_lim = LIM_X2;
      2'b10:   pre_lim = LIM_X4;
      default: pre_lim = LIM_X16;
    endcase
  end

  assign tick = tmr_busy && (pre == pre_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel      <= '0;
      count    <= '0;
      pre      <= '0;
      tmr_flag <= 1'b0;
      tmr_busy <= 1'b0;
    end else if (wr_en) begin
      sel      <= wr_data[CNT_W+1:CNT_W];
      count    <= wr_data[CNT_W-1:0];
      pre      <= '0;
      tmr_flag <= (wr_data[CNT_W-1:0] == '0);
      tmr_busy <= (wr_data[CNT_W-1:0] != '0);
    end else if (tick) begin
      pre   <= '0;
      count <= count - 1'b1;
      if (count == CNT_W'(1)) begin
        tmr_busy <= 1'b0;
        tmr_flag <= 1'b1;
      end
    end else if (tmr_busy) begin
      pre <= pre + 1'b1;
    end
  end

  // R8
  flag_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_flag && tmr_busy));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CNT_W-1:0] != '0) |=> (tmr_busy && !tmr_flag));

  // R5
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CNT_W-1:0] == '0) |=> (tmr_flag && !tmr_busy));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag && !wr_en) |=> tmr_flag);

  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmr_busy) |-> tmr_flag);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_busy && !wr_en) |=> !tmr_busy);
endmodule

// File: tb/test_oneshot_timer.sv
module test_oneshot_timer;
  localparam int BASE = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tmr_flag, tmr_busy;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  oneshot_timer #(.BASE_CYCLES(BASE)) i_oneshot_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tmr_flag(tmr_flag), .tmr_busy(tmr_busy)
  );

  function automatic int mult_of(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic int period_of(input logic [7:0] d);
    return int'(d[5:0]) * mult_of(d[7:6]) * BASE;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {flag,busy} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_interval(input logic [7:0] d, input string req);
    int p;
    p = period_of(d);
    write(d);
    if (p == 0) begin
      check({req, "/R5"}, {tmr_flag, tmr_busy}, 2'b10);
    end else begin
      check({req, "/R2"}, {tmr_flag, tmr_busy}, 2'b01);
      repeat (p - 1) @(negedge clk);
      check({req, "/R4 pre-edge"}, {tmr_flag, tmr_busy}, 2'b01);
      @(negedge clk);
      check({req, "/R4 edge"}, {tmr_flag, tmr_busy}, 2'b10);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 reset", {tmr_flag, tmr_busy}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {tmr_flag, tmr_busy}, 2'b00);

    // R3: every multiplier code with a small count
    run_interval(8'h05, "R3 x1");
    run_interval(8'h43, "R3 x2");
    run_interval(8'h82, "R3 x4");
    run_interval(8'hC2, "R3 x16");
    run_interval(8'h01, "R3 min count");
    run_interval(8'h3F, "R3 max count");
    run_interval(8'hFF, "R3 max period");
    run_interval(8'hC0, "R5 zero x16");

    // R6: flag holds with no writes
    run_interval(8'h02, "R6 setup");
    repeat (100) @(negedge clk);
    check("R6 sticky", {tmr_flag, tmr_busy}, 2'b10);

    // R7: restart mid-interval
    write(8'h05);
    repeat (7) @(negedge clk);
    check("R7 mid-count", {tmr_flag, tmr_busy}, 2'b01);
    run_interval(8'h42, "R7 restart");

    // R7: zero write aborts a running count
    write(8'hC8);
    repeat (10) @(negedge clk);
    run_interval(8'h00, "R7 abort");

    // random intervals
    for (int i = 0; i < 25; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      run_interval(d, "R3 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule